// File: doc/BRIEF.md
# Status Register Move Unit

This block handles the instruction that copies a general register into a program status word. It accepts either a 32-bit conditional encoding or a compact encoding built from two 16-bit halfwords, and a single input chooses which form the presented word holds. While an instruction is presented it decodes the target select, the 4-bit byte-lane mask and the source register index. It drives the source index on a register read port and takes the returned data back in the same cycle.

If the instruction is well formed, its condition passed and its source and mask are legal, the block raises a write strobe for either the current or the saved status word. On the next rising clock edge it merges the source data into that word, one byte lane per mask bit. An ill-formed or unpredictable instruction is decoded and flagged but never written. A failed condition drops the write without raising any flag.

Top module: `msr_unit`

## Requirements
- R1: The 32-bit form (`instr_compact`=0) is recognised when bits [27:23]=00010, [21:20]=10 and [7:4]=0000. Its target select is bit 22, its mask is bits [19:16] and its source index is bits [3:0]. While it is presented, `rs_addr` equals that source index.
- R2: The compact form (`instr_compact`=1) places the first halfword in `instr[31:16]` and the second in `instr[15:0]`. It is recognised when bits [31:21]=11110011100, [15:14]=10 and bit 12=0. Its target select is bit 20, its source index is bits [19:16] and its mask is bits [11:8].
- R3: A target select of 1 writes the saved status word through `sav_wr_en`, and 0 writes the current word through `cur_wr_en`. The two strobes are never high together.
- R4: Mask bit 3 enables status bits [31:24], bit 2 enables [23:16], bit 1 enables [15:8] and bit 0 enables [7:0]. Lanes whose mask bit is clear keep their value. During a write, `wr_lanes` equals the mask.
- R5: A write becomes visible on `cur_psr`/`sav_psr` after the rising edge that ends the decode cycle, and not before. With no strobe, both words hold their value.
- R6: A mask of 0000 raises `dec_unpred` and `dec_blocked` in either form and suppresses the write.
- R7: In the 32-bit form, source index 15 raises `dec_unpred` and blocks the write. Source index 13 is legal in this form.
- R8: In the compact form, source index 13 or 15 raises `dec_unpred` and blocks the write.
- R9: A should-be bit that mismatches raises `dec_blocked` with `dec_unpred` low and suppresses the write. In the 32-bit form these are bits [15:12] (expected 1111) and [11:8] (expected 0000). In the compact form they are bit 13 and bits [7:0] (expected 0).
- R10: With `cond_pass`=0, no write strobe rises and `dec_blocked` stays low.
- R11: If `instr_valid` is low or the encoding is not recognised, `dec_valid`, `dec_unpred`, `dec_blocked` and every strobe stay low.
- R12: After reset, both status words equal their reset parameters (zero by default) and no strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr_compact | input | 1 | 1: compact two-halfword form, 0: 32-bit form |
| instr | input | 32 | Instruction word |
| cond_pass | input | 1 | Condition check passed |
| rs_addr | output | 4 | Source register read index |
| rs_data | input | PSR_W | Source register read data |
| dec_valid | output | 1 | Recognised encoding presented |
| dec_spsr | output | 1 | Decoded target select (1 = saved word) |
| dec_mask | output | 4 | Decoded byte-lane mask |
| dec_rn | output | 4 | Decoded source index |
| dec_unpred | output | 1 | Unpredictable combination decoded |
| dec_blocked | output | 1 | Write suppressed by illegal content |
| cur_wr_en | output | 1 | Current status word write strobe |
| sav_wr_en | output | 1 | Saved status word write strobe |
| wr_lanes | output | PSR_W/8 | Byte lanes written |
| cur_psr | output | PSR_W | Current status word |
| sav_psr | output | PSR_W | Saved status word |

## Verification
The hardest case to reach is an instruction that is legal in one form and unpredictable in the other. Source index 13 must write in the 32-bit form and be refused in the compact form, so the stimulus issues it in both forms, each with a nonzero mask and otherwise clean bits. A second hard case is a should-be mismatch on an encoding that is otherwise perfect. Here the bench flips single bits in each should-be field and expects the blocked flag without the unpredictable flag. Throughout, the bench tracks both status words lane by lane, so a stray write to an untouched lane or to the wrong word appears in later checks.

// File: rtl/msr_pkg.sv
package msr_pkg;

  typedef struct packed {
    logic       match;
    logic       spsr;
    logic [3:0] mask;
    logic [3:0] rn;
    logic       sb_bad;
    logic       rn_bad;
  } msr_dec_t;

  localparam logic [3:0] RN_SP = 4'd13;
  localparam logic [3:0] RN_PC = 4'd15;

  function automatic logic wide_src_illegal(input logic [3:0] rn);
    return rn == RN_PC;
  endfunction

  function automatic logic compact_src_illegal(input logic [3:0] rn);
    return (rn == RN_PC) || (rn == RN_SP);
  endfunction

  function automatic logic mask_empty(input logic [3:0] m);
    return m == 4'b0000;
  endfunction

endpackage

// File: rtl/msr_dec_wide.sv
module msr_dec_wide
  import msr_pkg::*;
(
  input  logic [27:0] word,
  output msr_dec_t    d
);
  always_comb begin
    d.match  = (word[27:23] == 5'b00010) && (word[21:20] == 2'b10) &&
               (word[7:4] == 4'b0000);
    d.spsr   = word[22];
    d.mask   = word[19:16];
    d.rn     = word[3:0];
    d.sb_bad = (word[15:12] != 4'hF) || (word[11:8] != 4'h0);
    d.rn_bad = wide_src_illegal(word[3:0]);
  end
endmodule

// File: rtl/msr_dec_compact.sv
module msr_dec_compact
  import msr_pkg::*;
(
  input  logic [31:0] word,
  output msr_dec_t    d
);
  logic [15:0] hw_a;
  logic [15:0] hw_b;

  assign hw_a = word[31:16];
  assign hw_b = word[15:0];

  always_comb begin
    d.match  = (hw_a[15:5] == 11'b11110011100) && (hw_b[15:14] == 2'b10) &&
               !hw_b[12];
    d.spsr   = hw_a[4];
    d.rn     = hw_a[3:0];
    d.mask   = hw_b[11:8];
    d.sb_bad = hw_b[13] || (hw_b[7:0] != 8'h00);
    d.rn_bad = compact_src_illegal(hw_a[3:0]);
  end
endmodule

// File: rtl/msr_psr_reg.sv
module msr_psr_reg #(
  parameter int unsigned         W     = 32,
  parameter logic [W-1:0]        RESET = '0,
  localparam int unsigned        LANES = W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LANES-1:0] lanes,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     q
);
  logic [W-1:0] merged;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign merged[8*k +: 8] = lanes[k] ? wdata[8*k +: 8] : q[8*k +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RESET;
    else if (we) q <= merged;
  end
endmodule

// File: rtl/msr_unit.sv
module msr_unit
  import msr_pkg::*;
#(
  parameter int unsigned        PSR_W     = 32,
  parameter logic [PSR_W-1:0]   CUR_RESET = '0,
  parameter logic [PSR_W-1:0]   SAV_RESET = '0,
  localparam int unsigned       LANES     = PSR_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic             instr_compact,
  input  logic [31:0]      instr,
  input  logic             cond_pass,
  output logic [3:0]       rs_addr,
  input  logic [PSR_W-1:0] rs_data,
  output logic             dec_valid,
  output logic             dec_spsr,
  output logic [3:0]       dec_mask,
  output logic [3:0]       dec_rn,
  output logic             dec_unpred,
  output logic             dec_blocked,
  output logic             cur_wr_en,
  output logic             sav_wr_en,
  output logic [LANES-1:0] wr_lanes,
  output logic [PSR_W-1:0] cur_psr,
  output logic [PSR_W-1:0] sav_psr
);
  msr_dec_t d_wide, d_cmp, d_sel;
  logic     ev_write;

  msr_dec_wide u_dec_wide (.word(instr[27:0]), .d(d_wide));
  msr_dec_compact u_dec_cmp (.word(instr), .d(d_cmp));

  assign d_sel       = instr_compact ? d_cmp : d_wide;
  assign rs_addr     = d_sel.rn;
  assign dec_spsr    = d_sel.spsr;
  assign dec_mask    = d_sel.mask;
  assign dec_rn      = d_sel.rn;
  assign dec_valid   = instr_valid && d_sel.match;
  assign dec_unpred  = dec_valid && (d_sel.rn_bad || mask_empty(d_sel.mask));
  assign dec_blocked = dec_valid && (dec_unpred || d_sel.sb_bad);
  assign ev_write    = dec_valid && !dec_blocked && cond_pass;
  assign cur_wr_en   = ev_write && !d_sel.spsr;
  assign sav_wr_en   = ev_write && d_sel.spsr;
  assign wr_lanes    = ev_write ? LANES'(d_sel.mask) : '0;

  msr_psr_reg #(.W(PSR_W), .RESET(CUR_RESET)) u_cur (
    .clk(clk), .rst_n(rst_n), .we(cur_wr_en), .lanes(wr_lanes),
    .wdata(rs_data), .q(cur_psr)
  );

  msr_psr_reg #(.W(PSR_W), .RESET(SAV_RESET)) u_sav (
    .clk(clk), .rst_n(rst_n), .we(sav_wr_en), .lanes(wr_lanes),
    .wdata(rs_data), .q(sav_psr)
  );
endmodule

// File: rtl/msr_unit_chk.sv
module msr_unit_chk #(
  parameter int unsigned PSR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_valid,
  input logic             cond_pass,
  input logic [3:0]       rs_addr,
  input logic [PSR_W-1:0] rs_data,
  input logic             dec_valid,
  input logic             dec_spsr,
  input logic [3:0]       dec_mask,
  input logic [3:0]       dec_rn,
  input logic             dec_unpred,
  input logic             dec_blocked,
  input logic             cur_wr_en,
  input logic             sav_wr_en,
  input logic [3:0]       wr_lanes,
  input logic [PSR_W-1:0] cur_psr,
  input logic [PSR_W-1:0] sav_psr
);
  // R1
  src_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> rs_addr == dec_rn);

  // R3
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cur_wr_en && sav_wr_en));

  // R3
  target_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_wr_en |-> !dec_spsr) and (sav_wr_en |-> dec_spsr));

  // R4
  lanes_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_wr_en || sav_wr_en) |-> wr_lanes == dec_mask);

  // R4
  top_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_wr_en && wr_lanes[3]) |=> cur_psr[31:24] == $past(rs_data[31:24]));

  // R4
  low_lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_wr_en && !wr_lanes[0]) |=> $stable(cur_psr[7:0]));

  // R5
  cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_wr_en |=> $stable(cur_psr));

  // R5
  sav_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sav_wr_en |=> $stable(sav_psr));

  // R6
  unpred_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_unpred |-> (dec_blocked && !cur_wr_en && !sav_wr_en));

  // R10
  no_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !cond_pass) |-> (!cur_wr_en && !sav_wr_en));

  // R11
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (wr_lanes == 4'b0 && !dec_unpred && !dec_blocked));
endmodule

bind msr_unit msr_unit_chk u_chk (.*);

// File: tb/test_msr_unit.sv
module test_msr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_compact = 1'b0;
  logic [31:0] instr = '0;
  logic        cond_pass = 1'b1;
  logic [3:0]  rs_addr;
  logic [31:0] rs_data;
  logic        dec_valid, dec_spsr, dec_unpred, dec_blocked;
  logic [3:0]  dec_mask, dec_rn, wr_lanes;
  logic        cur_wr_en, sav_wr_en;
  logic [31:0] cur_psr, sav_psr;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] m_cur = '0;
  logic [31:0] m_sav = '0;

  always #4 clk = ~clk;

  function automatic logic [31:0] src_val(input logic [3:0] a);
    return 32'h9E3779B9 ^ {8{a}};
  endfunction

  assign rs_data = src_val(rs_addr);

  msr_unit i_msr_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
    .instr_compact(instr_compact), .instr(instr), .cond_pass(cond_pass),
    .rs_addr(rs_addr), .rs_data(rs_data), .dec_valid(dec_valid),
    .dec_spsr(dec_spsr), .dec_mask(dec_mask), .dec_rn(dec_rn),
    .dec_unpred(dec_unpred), .dec_blocked(dec_blocked),
    .cur_wr_en(cur_wr_en), .sav_wr_en(sav_wr_en), .wr_lanes(wr_lanes),
    .cur_psr(cur_psr), .sav_psr(sav_psr)
  );

  function automatic logic [31:0] enc_wide(input logic [3:0] cnd, input logic r,
      input logic [3:0] m, input logic [3:0] rn,
      input logic [3:0] s_hi = 4'hF, input logic [3:0] s_mid = 4'h0);
    return {cnd, 5'b00010, r, 2'b10, m, s_hi, s_mid, 4'b0000, rn};
  endfunction

  function automatic logic [31:0] enc_cmp(input logic r, input logic [3:0] rn,
      input logic [3:0] m, input logic b13 = 1'b0, input logic [7:0] lo = 8'h00);
    return {11'b11110011100, r, rn, 2'b10, b13, 1'b0, m, lo};
  endfunction

  function automatic logic [31:0] put_lanes(input logic [31:0] old,
      input logic [31:0] v, input logic [3:0] m);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (m[k]) r[8*k +: 8] = v[8*k +: 8];
    return r;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input string req, input logic cmp, input logic [31:0] w,
      input logic pass, input logic e_valid, input logic e_unp,
      input logic e_blk, input logic e_r, input logic [3:0] e_m,
      input logic [3:0] e_rn, input logic ivalid = 1'b1);
    logic wr;
    @(negedge clk);
    instr_valid = ivalid; instr_compact = cmp; instr = w; cond_pass = pass;
    #1;
    wr = e_valid && !e_blk && pass;
    chk(req, "dec_valid", 32'(dec_valid), 32'(e_valid));
    chk(req, "dec_unpred", 32'(dec_unpred), 32'(e_unp));
    chk(req, "dec_blocked", 32'(dec_blocked), 32'(e_blk));
    chk(req, "cur_wr_en", 32'(cur_wr_en), 32'(wr && !e_r));
    chk(req, "sav_wr_en", 32'(sav_wr_en), 32'(wr && e_r));
    chk(req, "wr_lanes", 32'(wr_lanes), wr ? 32'(e_m) : 32'h0);
    if (e_valid) begin
      chk(req, "dec_spsr", 32'(dec_spsr), 32'(e_r));
      chk(req, "dec_mask", 32'(dec_mask), 32'(e_m));
      chk(req, "dec_rn", 32'(dec_rn), 32'(e_rn));
      chk(req, "rs_addr", 32'(rs_addr), 32'(e_rn));
    end
    chk("R5", "cur_psr before edge", cur_psr, m_cur);
    chk("R5", "sav_psr before edge", sav_psr, m_sav);
    if (wr && !e_r) m_cur = put_lanes(m_cur, src_val(e_rn), e_m);
    if (wr && e_r)  m_sav = put_lanes(m_sav, src_val(e_rn), e_m);
    @(posedge clk); #1;
    instr_valid = 1'b0;
    chk(req, "cur_psr after edge", cur_psr, m_cur);
    chk(req, "sav_psr after edge", sav_psr, m_sav);
  endtask

  task automatic t_reset();
    chk("R12", "cur_psr reset", cur_psr, 32'h0);
    chk("R12", "sav_psr reset", sav_psr, 32'h0);
    chk("R12", "strobes reset", {30'h0, cur_wr_en, sav_wr_en}, 32'h0);
  endtask

  task automatic t_wide_writes();
    issue("R1", 0, enc_wide(4'hE, 0, 4'b1000, 4'd3), 1, 1, 0, 0, 0, 4'b1000, 4'd3);
    issue("R3", 0, enc_wide(4'h0, 1, 4'b1111, 4'd7), 1, 1, 0, 0, 1, 4'b1111, 4'd7);
    issue("R4", 0, enc_wide(4'hA, 0, 4'b0101, 4'd9), 1, 1, 0, 0, 0, 4'b0101, 4'd9);
    issue("R4", 0, enc_wide(4'hE, 1, 4'b0010, 4'd1), 1, 1, 0, 0, 1, 4'b0010, 4'd1);
  endtask

  task automatic t_wide_src();
    issue("R7", 0, enc_wide(4'hE, 0, 4'b0100, 4'd13), 1, 1, 0, 0, 0, 4'b0100, 4'd13);
    issue("R7", 0, enc_wide(4'hE, 0, 4'b1100, 4'd15), 1, 1, 1, 1, 0, 4'b1100, 4'd15);
  endtask

  task automatic t_mask_zero();
    issue("R6", 0, enc_wide(4'hE, 0, 4'b0000, 4'd2), 1, 1, 1, 1, 0, 4'b0000, 4'd2);
    issue("R6", 1, enc_cmp(1, 4'd2, 4'b0000), 1, 1, 1, 1, 1, 4'b0000, 4'd2);
  endtask

  task automatic t_compact();
    issue("R2", 1, enc_cmp(0, 4'd2, 4'b1100), 1, 1, 0, 0, 0, 4'b1100, 4'd2);
    issue("R2", 1, enc_cmp(1, 4'd12, 4'b0011), 1, 1, 0, 0, 1, 4'b0011, 4'd12);
    issue("R8", 1, enc_cmp(0, 4'd13, 4'b1000), 1, 1, 1, 1, 0, 4'b1000, 4'd13);
    issue("R8", 1, enc_cmp(1, 4'd15, 4'b1111), 1, 1, 1, 1, 1, 4'b1111, 4'd15);
  endtask

  task automatic t_should_be();
    issue("R9", 0, enc_wide(4'hE, 0, 4'b1111, 4'd4, 4'hE, 4'h0), 1, 1, 0, 1, 0, 4'b1111, 4'd4);
    issue("R9", 0, enc_wide(4'hE, 1, 4'b1111, 4'd4, 4'hF, 4'h8), 1, 1, 0, 1, 1, 4'b1111, 4'd4);
    issue("R9", 1, enc_cmp(0, 4'd5, 4'b1111, 1'b1, 8'h00), 1, 1, 0, 1, 0, 4'b1111, 4'd5);
    issue("R9", 1, enc_cmp(1, 4'd5, 4'b1111, 1'b0, 8'h20), 1, 1, 0, 1, 1, 4'b1111, 4'd5);
  endtask

  task automatic t_no_pass();
    issue("R10", 0, enc_wide(4'h1, 0, 4'b1111, 4'd6), 0, 1, 0, 0, 0, 4'b1111, 4'd6);
    issue("R10", 1, enc_cmp(1, 4'd6, 4'b1111), 0, 1, 0, 0, 1, 4'b1111, 4'd6);
  endtask

  task automatic t_unrecognised();
    issue("R11", 0, enc_wide(4'hE, 0, 4'b1111, 4'd3) ^ 32'h0080_0000, 1, 0, 0, 0, 0, 4'b0, 4'd0);
    issue("R11", 1, enc_cmp(0, 4'd3, 4'b1111) | 32'h0000_1000, 1, 0, 0, 0, 0, 4'b0, 4'd0);
    issue("R11", 0, enc_wide(4'hE, 0, 4'b0000, 4'd15), 1, 0, 0, 0, 0, 4'b0, 4'd0, 1'b0);
    issue("R11", 1, enc_cmp(0, 4'd3, 4'b1111), 1, 0, 0, 0, 0, 4'b0, 4'd0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_wide_writes();
    t_wide_src();
    t_mask_zero();
    t_compact();
    t_should_be();
    t_no_pass();
    t_unrecognised();
    finish_run();
  end
endmodule